// File: doc/BRIEF.md
# Two-Bit-Per-Stage Magnitude Comparator

This block compares two operands of equal, even width and reports whether the first is less than, equal to or greater than the second. Each stage looks at two bit positions of both operands at once. Stages are chained from the least significant pair toward the most significant pair, so a result ripples through only half as many stages as there are bits. The first stage sees an "equal" input code.

A two-bit result code moves between stages. Code 00 means equal so far, 01 means the first operand is greater, and 11 means it is less. Code 10 is never formed. Because bit 0 of the code is set exactly when a difference has been found, the incoming code needs only two logic levels to reach either output of a stage.

A mode input selects two's complement comparison. In that mode the operands' sign bits, which form the upper pair of the top stage, enter that stage crossed over. The final code is brought out directly and also decoded into one-hot less, equal and greater flags. The block is purely combinational. An odd width is rejected at elaboration.

Top module: `cmp2_chain`

## Requirements
- R1: `eq_o` is 1 exactly when `a_i` equals `b_i` bit for bit, in either mode, and `code_o` is then 00.
- R2: With `is_signed_i` = 0, `gt_o` is 1 exactly when `a_i` > `b_i` as unsigned numbers, and `code_o` is then 01.
- R3: With `is_signed_i` = 0, `lt_o` is 1 exactly when `a_i` < `b_i` as unsigned numbers, and `code_o` is then 11.
- R4: Exactly one of `lt_o`, `eq_o` and `gt_o` is 1 at all times, and `code_o` never takes the value 10.
- R5: With `is_signed_i` = 1, the operands are read as two's complement numbers whose sign is bit WIDTH-1. `lt_o`/`gt_o` and `code_o` (11 for less, 01 for greater) follow that signed order.
- R6: Within a stage, a difference in the upper bit pair decides the stage output. Failing that, a difference in the lower pair decides it. When both pairs match, the code from the stage below passes through unchanged. A difference in a more significant pair therefore overrides any difference below it.
- R7: Bit 0 of `code_o` is 1 exactly when the operands differ in any bit.
- R8: Outputs follow the inputs with no clock and no register. A result is valid in the same cycle the operands are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| is_signed_i | input | 1 | 1 selects two's complement comparison, 0 selects unsigned |
| lt_o | output | 1 | First operand is less than the second |
| eq_o | output | 1 | Operands are equal |
| gt_o | output | 1 | First operand is greater than the second |
| code_o | output | 2 | Final result code: 00 equal, 01 greater, 11 less |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the operands and the outputs. The bench changes the operands and the mode on the falling edge. It compares all outputs against its own integer model 1 ns after the next rising edge, well after the logic has settled. Three instances of width 2, 4 and 6 are swept exhaustively over every operand pair in both modes at the same time. Directed cases then check pair priority at width 6.

// File: rtl/cmp2_pkg.sv
package cmp2_pkg;

  typedef enum logic [1:0] {
    CODE_EQ = 2'b00,
    CODE_GT = 2'b01,
    CODE_BAD = 2'b10,
    CODE_LT = 2'b11
  } cmp_code_e;

  // Two bit positions merged with the code arriving from below.
  // The incoming code reaches each output through one AND and one OR level.
  function automatic logic [1:0] pair_step(
    input logic       ah,
    input logic       bh,
    input logic       al,
    input logic       bl,
    input logic [1:0] cin
  );
    logic dh;
    logic dl;
    logic [1:0] r;
    dh = ah ^ bh;
    dl = al ^ bl;
    r[0] = dh | dl | cin[0];
    r[1] = (dh & bh) | (~dh & dl & bl) | (~dh & ~dl & cin[1]);
    return r;
  endfunction

endpackage

// File: rtl/cmp2_slice.sv
module cmp2_slice
  import cmp2_pkg::*;
(
  input  logic       hi_a,
  input  logic       hi_b,
  input  logic       lo_a,
  input  logic       lo_b,
  input  logic [1:0] code_in,
  output logic [1:0] code_out
);

  always_comb begin
    code_out = pair_step(hi_a, hi_b, lo_a, lo_b, code_in);
  end

endmodule

// File: rtl/cmp2_decode.sv
module cmp2_decode
  import cmp2_pkg::*;
(
  input  logic [1:0] code,
  output logic       lt,
  output logic       eq,
  output logic       gt
);

  always_comb begin
    lt = (code == CODE_LT);
    eq = (code == CODE_EQ);
    gt = (code == CODE_GT);
  end

endmodule

// File: rtl/cmp2_chain.sv
module cmp2_chain
  import cmp2_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             is_signed_i,
  output logic             lt_o,
  output logic             eq_o,
  output logic             gt_o,
  output logic [1:0]       code_o
);

  localparam int NSLICE = WIDTH / 2;

  generate
    if ((WIDTH % 2) != 0 || WIDTH < 2) begin : g_bad_width
      $error("cmp2_chain: WIDTH must be even and at least 2");
    end
  endgenerate

  // carry[k] enters slice k; carry[NSLICE] is the final code.
  logic [NSLICE:0][1:0] carry;

  assign carry[0] = CODE_EQ;

  generate
    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
      logic hi_a_sel;
      logic hi_b_sel;
      if (k == NSLICE - 1) begin : g_top
        // Sign bits cross over in two's complement mode.
        assign hi_a_sel = is_signed_i ? b_i[2*k+1] : a_i[2*k+1];
        assign hi_b_sel = is_signed_i ? a_i[2*k+1] : b_i[2*k+1];
      end else begin : g_mid
        assign hi_a_sel = a_i[2*k+1];
        assign hi_b_sel = b_i[2*k+1];
      end
      cmp2_slice u_slice (
        .hi_a    (hi_a_sel),
        .hi_b    (hi_b_sel),
        .lo_a    (a_i[2*k]),
        .lo_b    (b_i[2*k]),
        .code_in (carry[k]),
        .code_out(carry[k+1])
      );
    end
  endgenerate

  assign code_o = carry[NSLICE];

  cmp2_decode u_decode (
    .code(carry[NSLICE]),
    .lt  (lt_o),
    .eq  (eq_o),
    .gt  (gt_o)
  );

endmodule

// File: rtl/cmp2_chain_chk.sv
module cmp2_chain_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0]            a_i,
  input logic [WIDTH-1:0]            b_i,
  input logic                        is_signed_i,
  input logic                        lt_o,
  input logic                        eq_o,
  input logic                        gt_o,
  input logic [1:0]                  code_o,
  input logic [WIDTH/2:0][1:0]       carry
);

  localparam int NSLICE = WIDTH / 2;

  always_comb begin
    AST_EQ_MATCH: assert (eq_o == (a_i == b_i)); // R1
    AST_ONE_FLAG: assert ($onehot({lt_o, eq_o, gt_o})); // R4
    AST_NO_BAD_CODE: assert (code_o != 2'b10); // R4
    AST_DIFF_BIT: assert (code_o[0] == (a_i != b_i)); // R7
    if (!is_signed_i) begin
      AST_UNS_GT: assert (gt_o == (a_i > b_i)); // R2
      AST_UNS_LT: assert (lt_o == (a_i < b_i)); // R3
    end else begin
      AST_SGN_ORDER: assert (gt_o == ($signed(a_i) > $signed(b_i))); // R5
    end
  end

  generate
    for (genvar k = 0; k < NSLICE; k++) begin : g_pass
      always_comb begin
        if (a_i[2*k+1:2*k] == b_i[2*k+1:2*k]) begin
          AST_PAIR_PASS: assert (carry[k+1] == carry[k]); // R6
        end
      end
    end
  endgenerate

endmodule

bind cmp2_chain cmp2_chain_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i        (a_i),
  .b_i        (b_i),
  .is_signed_i(is_signed_i),
  .lt_o       (lt_o),
  .eq_o       (eq_o),
  .gt_o       (gt_o),
  .code_o     (code_o),
  .carry      (carry)
);

// File: tb/cmp2_chain_test.sv
module cmp2_chain_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic       sgn;
  logic [5:0] a6, b6;
  logic [3:0] a4, b4;
  logic [1:0] a2, b2;
  logic lt6, eq6, gt6, lt4, eq4, gt4, lt2, eq2, gt2;
  logic [1:0] c6, c4, c2;

  cmp2_chain #(.WIDTH(6)) uut (
    .a_i(a6), .b_i(b6), .is_signed_i(sgn),
    .lt_o(lt6), .eq_o(eq6), .gt_o(gt6), .code_o(c6));
  cmp2_chain #(.WIDTH(4)) uut_w4 (
    .a_i(a4), .b_i(b4), .is_signed_i(sgn),
    .lt_o(lt4), .eq_o(eq4), .gt_o(gt4), .code_o(c4));
  cmp2_chain #(.WIDTH(2)) uut_w2 (
    .a_i(a2), .b_i(b2), .is_signed_i(sgn),
    .lt_o(lt2), .eq_o(eq2), .gt_o(gt2), .code_o(c2));

  function automatic int to_int(input int raw, input int w, input bit s);
    if (s && raw >= (1 << (w - 1))) return raw - (1 << w);
    return raw;
  endfunction

  // Expected {code, lt, eq, gt} from integer ordering.
  function automatic logic [4:0] expect5(input int x, input int y);
    if (x == y) return 5'b00_010;
    if (x > y)  return 5'b01_001;
    return 5'b11_100;
  endfunction

  task automatic check_one(input string tag, input int w, input int ra, input int rb,
                           input bit s, input logic [4:0] got);
    logic [4:0] exp;
    int x, y;
    x = to_int(ra, w, s);
    y = to_int(rb, w, s);
    exp = expect5(x, y);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s w=%0d a=%0d b=%0d signed=%0d got=%b expected=%b",
               tag, w, ra, rb, s, got, exp);
    end
  endtask

  function automatic string tag_for(input int ra, input int rb, input int w, input bit s);
    int x, y;
    x = to_int(ra, w, s);
    y = to_int(rb, w, s);
    if (x == y) return "R1/R4/R7/R8";
    if (s) return "R5/R4/R7/R8";
    if (x > y) return "R2/R4/R7/R8";
    return "R3/R4/R7/R8";
  endfunction

  task automatic check_all();
    check_one(tag_for(int'(a6), int'(b6), 6, sgn), 6, int'(a6), int'(b6), sgn, {c6, lt6, eq6, gt6});
    check_one(tag_for(int'(a4), int'(b4), 4, sgn), 4, int'(a4), int'(b4), sgn, {c4, lt4, eq4, gt4});
    check_one(tag_for(int'(a2), int'(b2), 2, sgn), 2, int'(a2), int'(b2), sgn, {c2, lt2, eq2, gt2});
  endtask

  task automatic apply(input bit s, input logic [5:0] x6, input logic [5:0] y6,
                       input logic [3:0] x4, input logic [3:0] y4,
                       input logic [1:0] x2, input logic [1:0] y2);
    @(negedge clk);
    sgn = s; a6 = x6; b6 = y6; a4 = x4; b4 = y4; a2 = x2; b2 = y2;
    @(posedge clk);
    #1;
  endtask

  task automatic directed6(input string tag, input bit s, input logic [5:0] x, input logic [5:0] y);
    apply(s, x, y, 4'd0, 4'd0, 2'd0, 2'd0);
    check_one(tag, 6, int'(x), int'(y), s, {c6, lt6, eq6, gt6});
  endtask

  initial begin
    sgn = 1'b0; a6 = '0; b6 = '0; a4 = '0; b4 = '0; a2 = '0; b2 = '0;
    repeat (3) @(posedge clk);
    #1;
    // Initial state: zero operands compare equal (R1)
    check_all();
    rst_n = 1'b1;

    // Exhaustive sweep: every pair at widths 6, 4 and 2, both modes
    for (int i = 0; i < 8192; i++) begin
      apply(i[12], i[11:6], i[5:0], i[9:6], i[3:0], i[7:6], i[1:0]);
      check_all();
    end

    // R6: upper pair of the top stage overrides all lower differences
    directed6("R6 top-pair priority", 1'b0, 6'b10_00_00, 6'b01_11_11);
    // R6: upper bit of a stage overrides its lower bit
    directed6("R6 upper-over-lower", 1'b0, 6'b00_10_00, 6'b00_01_11);
    // R6: lower bit decides when upper bits match, overriding the stage below
    directed6("R6 lower-decides", 1'b0, 6'b00_01_00, 6'b00_00_11);
    // R6: matching pairs pass the code from below
    directed6("R6 pass-through", 1'b0, 6'b11_11_01, 6'b11_11_10);
    // R5: sign crossover, negative below positive
    directed6("R5 sign crossover", 1'b1, 6'b100000, 6'b011111);
    // R5: both negative, magnitude bits decide
    directed6("R5 both negative", 1'b1, 6'b111110, 6'b111101);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired R8 actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule